// File: doc/BRIEF.md
# Indirect PHY Register Access Bridge

This bridge gives a host processor access to a small private bank of byte-wide PHY registers through two 32-bit words on its memory-mapped register port. The control word at host offset 0x300 carries the PHY register offset, the transfer direction and a busy flag. The data word at host offset 0x304 is a mailbox. Software loads it before a write, or reads the fetched byte from it after a read.

A single host write to the control word starts one PHY transaction. The bridge latches the offset and direction and sets busy. It then holds a request to the PHY until the PHY acknowledges. On that acknowledge busy drops, and for a read the PHY byte is loaded into the mailbox. Software polls the busy flag to learn when the transaction has finished. While busy is set, host writes to either word are dropped, so the values presented to the PHY cannot change in the middle of a transaction.

Top module: `phy_reg_bridge`

## Requirements
- R1: After reset, the control word and the data word both read 0x00000000 and phy_req is low.
- R2: The control word reads as follows. Bits [7:0] give the latched PHY offset, bit 8 gives the direction (1 = write, 0 = read), bit 9 gives busy, and bits [31:10] read zero. The data word reads its byte in bits [7:0] and zero above. Written bits beyond these fields are discarded, and bit 9 of a host write has no effect of its own.
- R3: A host write to offset 0x300 while idle starts a transaction. From the next cycle busy reads 1 and phy_req is high. phy_addr equals written bits [7:0], and phy_we equals written bit 8.
- R4: phy_req stays high, with phy_addr, phy_we and phy_wdata stable, until phy_ack is sampled high. The PHY may raise phy_ack 1 to 15 cycles after the request, and busy reads 0 from the cycle after that acknowledge. phy_ack while no request is pending has no effect.
- R5: For a write transaction, phy_wdata equals the data word byte, and the data word keeps that value after the transaction ends.
- R6: For a read transaction, the data word byte takes the value of phy_rdata in the acknowledge cycle. Values present on phy_rdata in other cycles are not captured.
- R7: While busy is set, host writes to the control word and to the data word are ignored. This includes a write in the acknowledge cycle itself.
- R8: Host writes to any other offset change nothing, and host reads of any other offset return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_valid | input | 1 | Host register access request |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | 12 | Host byte offset |
| host_wdata | input | 32 | Host write data |
| host_ready | output | 1 | Access accepted (always high) |
| host_rdata | output | 32 | Read data for host_addr, combinational |
| phy_req | output | 1 | PHY transaction request |
| phy_we | output | 1 | PHY transaction direction, 1 = write |
| phy_addr | output | 8 | PHY register offset |
| phy_wdata | output | 8 | PHY write byte |
| phy_rdata | input | 8 | PHY read byte |
| phy_ack | input | 1 | PHY acknowledge |

## Verification
The PHY acknowledge, which clears busy and may load the mailbox, can land in the same cycle as a host write to the control or data word. The bench raises phy_ack and a host write on the same clock edge, once aimed at each word. It then reads both words back. The outcome is judged correct when the offset and direction are those of the finished transaction, busy is clear, and the mailbox holds the PHY byte rather than the host value.

// File: rtl/phy_reg_bridge.sv
module phy_reg_bridge #(
  parameter int          HOST_AW  = 12,
  parameter logic [11:0] CTRL_OFS = 12'h300,
  parameter logic [11:0] DATA_OFS = 12'h304,
  parameter int          PHY_AW   = 8,
  parameter int          PHY_DW   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_valid,
  input  logic               host_write,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [31:0]        host_wdata,
  output logic               host_ready,
  output logic [31:0]        host_rdata,
  output logic               phy_req,
  output logic               phy_we,
  output logic [PHY_AW-1:0]  phy_addr,
  output logic [PHY_DW-1:0]  phy_wdata,
  input  logic [PHY_DW-1:0]  phy_rdata,
  input  logic               phy_ack
);
  localparam int CTRL_PAD = 32 - PHY_AW - 2;
  localparam int DATA_PAD = 32 - PHY_DW;

  logic [PHY_AW-1:0] addr_q;
  logic [PHY_DW-1:0] data_q;
  logic              dir_q, busy_q;
  logic              hit_ctrl, hit_data, wr_ctrl, wr_data, done;
  logic [31:0]       ctrl_word, data_word;
  logic              unused_ok;

  assign hit_ctrl = host_addr == HOST_AW'(CTRL_OFS);
  assign hit_data = host_addr == HOST_AW'(DATA_OFS);
  assign wr_ctrl  = host_valid && host_write && hit_ctrl && !busy_q;
  assign wr_data  = host_valid && host_write && hit_data && !busy_q;
  assign done     = busy_q && phy_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      dir_q  <= 1'b0;
      busy_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (wr_ctrl) begin
        addr_q <= host_wdata[PHY_AW-1:0];
        dir_q  <= host_wdata[PHY_AW];
        busy_q <= 1'b1;
      end
      if (wr_data) data_q <= host_wdata[PHY_DW-1:0];
      if (done) begin
        busy_q <= 1'b0;
        if (!dir_q) data_q <= phy_rdata;
      end
    end
  end

  assign ctrl_word  = {{CTRL_PAD{1'b0}}, busy_q, dir_q, addr_q};
  assign data_word  = {{DATA_PAD{1'b0}}, data_q};
  assign host_rdata = hit_ctrl ? ctrl_word : hit_data ? data_word : 32'h0;
  assign host_ready = 1'b1;

  assign phy_req   = busy_q;
  assign phy_we    = dir_q;
  assign phy_addr  = addr_q;
  assign phy_wdata = data_q;

  assign unused_ok = ^host_wdata;
endmodule

// File: rtl/phy_reg_bridge_chk.sv
module phy_reg_bridge_chk #(
  parameter int          HOST_AW  = 12,
  parameter logic [11:0] CTRL_OFS = 12'h300,
  parameter int          PHY_AW   = 8,
  parameter int          PHY_DW   = 8,
  parameter int          ACK_MAX  = 15
) (
  input logic               clk,
  input logic               rst_n,
  input logic               host_valid,
  input logic               host_write,
  input logic [HOST_AW-1:0] host_addr,
  input logic               phy_req,
  input logic               phy_we,
  input logic [PHY_AW-1:0]  phy_addr,
  input logic [PHY_DW-1:0]  phy_wdata,
  input logic [PHY_DW-1:0]  phy_rdata,
  input logic               phy_ack,
  input logic [PHY_DW-1:0]  data_q
);
  logic [4:0] wait_cnt;
  logic       ctrl_wr;
  assign ctrl_wr = host_valid && host_write && host_addr == HOST_AW'(CTRL_OFS);

  always_ff @(posedge clk) begin
    if (!rst_n) wait_cnt <= '0;
    else if (phy_req && phy_ack) wait_cnt <= '0;
    else if (phy_req && wait_cnt != 5'd31) wait_cnt <= wait_cnt + 5'd1;
  end

  AST_START_REQ:    assert property (@(posedge clk) disable iff (!rst_n) ctrl_wr && !phy_req |=> phy_req); // R3
  AST_REQ_HOLD:     assert property (@(posedge clk) disable iff (!rst_n) phy_req && !phy_ack |=> phy_req); // R4
  AST_REQ_STABLE:   assert property (@(posedge clk) disable iff (!rst_n) phy_req && !phy_ack |=> $stable(phy_addr) && $stable(phy_we) && $stable(phy_wdata)); // R4
  AST_REQ_DROP:     assert property (@(posedge clk) disable iff (!rst_n) phy_req && phy_ack |=> !phy_req); // R4
  AST_ACK_WINDOW:   assert property (@(posedge clk) disable iff (!rst_n) phy_req && phy_ack |-> wait_cnt < 5'(ACK_MAX)); // R4
  AST_WR_KEEP:      assert property (@(posedge clk) disable iff (!rst_n) phy_req && phy_ack && phy_we |=> $stable(data_q)); // R5
  AST_RD_CAPTURE:   assert property (@(posedge clk) disable iff (!rst_n) phy_req && phy_ack && !phy_we |=> data_q == $past(phy_rdata)); // R6
  AST_BUSY_IGNORE:  assert property (@(posedge clk) disable iff (!rst_n) phy_req && ctrl_wr |=> $stable(phy_addr) && $stable(phy_we)); // R7
endmodule

bind phy_reg_bridge phy_reg_bridge_chk #(
  .HOST_AW(HOST_AW), .CTRL_OFS(CTRL_OFS), .PHY_AW(PHY_AW), .PHY_DW(PHY_DW), .ACK_MAX(15)
) u_chk (
  .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_write(host_write),
  .host_addr(host_addr), .phy_req(phy_req), .phy_we(phy_we), .phy_addr(phy_addr),
  .phy_wdata(phy_wdata), .phy_rdata(phy_rdata), .phy_ack(phy_ack), .data_q(data_q)
);

// File: tb/phy_reg_bridge_test.sv
module phy_reg_bridge_test;
  logic        clk = 0, rst_n = 0;
  logic        host_valid = 0, host_write = 0;
  logic [11:0] host_addr = 0;
  logic [31:0] host_wdata = 0;
  logic        host_ready;
  logic [31:0] host_rdata;
  logic        phy_req, phy_we, phy_ack = 0;
  logic [7:0]  phy_addr, phy_wdata, phy_rdata = 8'hEE;

  int checks = 0, fails = 0;
  bit done_flag = 0;

  localparam logic [11:0] CTRL = 12'h300, DATA = 12'h304;

  phy_reg_bridge uut (
    .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_write(host_write),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_ready(host_ready),
    .host_rdata(host_rdata), .phy_req(phy_req), .phy_we(phy_we), .phy_addr(phy_addr),
    .phy_wdata(phy_wdata), .phy_rdata(phy_rdata), .phy_ack(phy_ack)
  );

  always #4 clk = ~clk;

  // {dir, phy offset, byte, ack delay}
  localparam logic [20:0] VEC [8] = '{
    {1'b1, 8'h10, 8'hE8, 4'd1},  {1'b0, 8'h20, 8'h3C, 4'd1},
    {1'b1, 8'hFF, 8'h00, 4'd15}, {1'b0, 8'h00, 8'hFF, 4'd15},
    {1'b1, 8'h5A, 8'hA5, 4'd7},  {1'b0, 8'h7E, 8'h81, 4'd3},
    {1'b1, 8'h01, 8'hFF, 4'd2},  {1'b0, 8'hC4, 8'h00, 4'd9}
  };

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic host_wr(input logic [11:0] a, input logic [31:0] d);
    host_valid = 1; host_write = 1; host_addr = a; host_wdata = d;
    @(posedge clk); @(negedge clk);
    host_valid = 0; host_write = 0;
  endtask

  task automatic host_rd(input logic [11:0] a, output logic [31:0] d);
    host_valid = 1; host_write = 0; host_addr = a;
    #1 d = host_rdata;
    host_valid = 0;
  endtask

  // Acknowledge after n request cycles; optionally collide with a host write.
  task automatic respond(input int n, input logic [7:0] rb, input bit coll,
                         input logic [11:0] ca, input logic [31:0] cd, output bit stable_ok);
    logic [7:0] a0, w0; logic we0; logic [31:0] rd;
    a0 = phy_addr; w0 = phy_wdata; we0 = phy_we;
    stable_ok = phy_req;
    for (int i = 1; i < n; i++) begin
      @(negedge clk);
      if (!phy_req || phy_addr !== a0 || phy_wdata !== w0 || phy_we !== we0) stable_ok = 0;
    end
    host_rd(CTRL, rd);
    if (rd[9] !== 1'b1) stable_ok = 0;
    phy_ack = 1; phy_rdata = rb;
    if (coll) begin host_valid = 1; host_write = 1; host_addr = ca; host_wdata = cd; end
    @(negedge clk);
    phy_ack = 0; phy_rdata = 8'hEE; host_valid = 0; host_write = 0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done_flag) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd; bit ok;
    repeat (3) @(negedge clk);
    host_rd(CTRL, rd); chk(rd, 32'h0, "R1 ctrl reset");
    host_rd(DATA, rd); chk(rd, 32'h0, "R1 data reset");
    chk({31'b0, phy_req}, 32'h0, "R1 phy_req reset");
    rst_n = 1;
    @(negedge clk);

    foreach (VEC[k]) begin
      logic d; logic [7:0] a, b; int n;
      {d, a, b} = VEC[k][20:4]; n = int'(VEC[k][3:0]);
      host_wr(DATA, d ? {24'h0, b} : {24'h0, ~b});
      host_wr(CTRL, {23'h0, d, a});
      chk({31'b0, phy_req}, 32'h1, "R3 request raised");
      chk({23'b0, phy_we, phy_addr}, {23'b0, d, a}, "R3 phy addr/dir");
      if (d) chk({24'b0, phy_wdata}, {24'b0, b}, "R5 phy wdata");
      respond(n, d ? 8'h66 : b, 0, 12'h0, 32'h0, ok);
      chk({31'b0, ok}, 32'h1, "R4 request held stable while busy");
      host_rd(CTRL, rd); chk(rd, {23'h0, d, a}, "R4 busy cleared after ack");
      host_rd(DATA, rd);
      if (d) chk(rd, {24'h0, b}, "R5 data kept after write");
      else   chk(rd, {24'h0, b}, "R6 read byte captured");
    end

    // R2 field layout and discarded bits
    host_wr(DATA, 32'hABCD_12C3);
    host_rd(DATA, rd); chk(rd, 32'h0000_00C3, "R2 data upper bits zero");
    host_wr(CTRL, 32'hFFFF_FE12);
    host_rd(CTRL, rd); chk(rd, 32'h0000_0212, "R2 ctrl layout while busy");
    // R7 writes while busy, mid transaction
    host_wr(DATA, 32'h99);
    host_wr(CTRL, 32'h0155);
    chk({23'b0, phy_we, phy_addr}, 32'h012, "R7 ctrl write ignored while busy");
    respond(3, 8'h4D, 0, 12'h0, 32'h0, ok);
    host_rd(DATA, rd); chk(rd, 32'h4D, "R7 data write ignored, R6 capture");

    // R7 collision in ack cycle with ctrl write
    host_wr(CTRL, 32'h0033);
    respond(2, 8'h5A, 1, CTRL, 32'h0144, ok);
    host_rd(CTRL, rd); chk(rd, 32'h0000_0033, "R7 ctrl write in ack cycle ignored");
    host_rd(DATA, rd); chk(rd, 32'h5A, "R7 ack cycle read capture");
    // R7 collision in ack cycle with data write
    host_wr(CTRL, 32'h0034);
    respond(4, 8'hC8, 1, DATA, 32'h77, ok);
    host_rd(DATA, rd); chk(rd, 32'hC8, "R7 data write in ack cycle ignored");

    // R4 stray ack while idle
    phy_ack = 1; phy_rdata = 8'h11; @(negedge clk); phy_ack = 0; phy_rdata = 8'hEE;
    host_rd(DATA, rd); chk(rd, 32'hC8, "R4 idle ack ignored");
    chk({31'b0, phy_req}, 32'h0, "R4 no request after idle ack");

    // R8 other offsets
    host_wr(12'h308, 32'h0000_01AA);
    chk({31'b0, phy_req}, 32'h0, "R8 other offset starts nothing");
    host_rd(12'h308, rd); chk(rd, 32'h0, "R8 other offset reads zero");
    host_rd(CTRL, rd); chk(rd, 32'h0000_0034, "R8 ctrl untouched");

    // R1 reset mid transaction
    host_wr(CTRL, 32'h0122);
    rst_n = 0; @(negedge clk); rst_n = 1;
    host_rd(CTRL, rd); chk(rd, 32'h0, "R1 reset clears busy");
    host_rd(DATA, rd); chk(rd, 32'h0, "R1 reset clears data");

    done_flag = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule